// File: doc/BRIEF.md
# Transport Packet Output Formatter

This block sits after a packet decoder and turns its stream of decoded transport bytes into an output port for a downstream demultiplexer. The port is driven with a data clock, a strobe, a frame-start marker and a data-valid qualifier. It can run as an 8-bit parallel bus or as a single serial line, and in either burst timing or evenly paced timing.

Bytes enter through a valid/ready handshake into a small FIFO. The FIFO absorbs upstream bursts and lets the output side set its own pace. The block counts bytes to find packet boundaries. The packet length is either 188 or 144 bytes, chosen by a configuration input. All configuration inputs are expected to stay constant while the block is out of reset.

Every output unit (a byte in parallel form, a bit in serial form) takes one period of the data clock. The clock is low for the first half of the period and high for the rest. Output data changes only when the data clock falls, so it is stable around the rising edge, which is the active edge.

Top module: `ts_pkt_formatter`

## Requirements
- R1: With `cfg_short_len`=0 a packet is 188 bytes, and with `cfg_short_len`=1 it is 144 bytes. Counting from reset, byte k accepted at the input is the first byte of a packet exactly when k modulo the packet length is 0.
- R2: In parallel form (`cfg_serial`=0), each byte is shown whole on `out_data[7:0]` for one unit. `out_stb` is high during the high phase of `out_clk` for every emitted byte, and low at all other times.
- R3: In serial form (`cfg_serial`=1), each byte is sent on `out_data[0]` as 8 consecutive units, most significant bit first, and `out_data[7:1]` stays 0. Outside the per-byte marking mode of R5, `out_stb` is high in the high phase of every bit.
- R4: `out_sync` is high for the first byte of each packet only. In parallel form this is one unit. In serial form outside the R5 mode it covers all 8 bit units of that byte.
- R5: In the per-byte marking mode (`cfg_serial`=1, `cfg_regulated`=1, `cfg_byte_mark`=1), `out_stb` is high for the whole first bit unit of each byte and low for its other 7 bits. In this mode `out_sync` is high only for the first bit unit of a packet.
- R6: `out_valid` is low in idle units, when no byte is available. It is also low for any byte that entered with `in_err`=1. Such a byte is still emitted, strobed and counted toward the packet length.
- R7: In normal timing (`cfg_regulated`=0), a unit lasts 2 clocks, and bytes leave back to back for as long as the FIFO holds data.
- R8: In regulated timing, a unit lasts `cfg_pace` clocks, and values below 2 count as 2. `out_clk` runs continuously, and idle units fill any time when no data is ready.
- R9: For a unit of P clocks, `out_clk` is low for floor(P/2) clocks and then high for the rest. `out_data` and the rise of `out_sync` change only in the cycle where `out_clk` falls.
- R10: `in_ready` is low exactly when the FIFO holds `FIFO_DEPTH` entries. A byte is taken only when `in_valid` and `in_ready` are both high, and every byte taken appears at the output once, in order.
- R11: While `rst_n` is low, `out_clk`, `out_stb`, `out_sync`, `out_valid` and `out_data` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_short_len | input | 1 | 0: 188-byte packets, 1: 144-byte packets |
| cfg_serial | input | 1 | 0: parallel byte bus, 1: single-bit serial line |
| cfg_regulated | input | 1 | 0: burst timing, 1: paced timing |
| cfg_byte_mark | input | 1 | Serial paced mode only: strobe marks byte starts instead of every bit |
| cfg_pace | input | PACE_W | Clocks per output unit in paced timing |
| in_valid | input | 1 | Upstream byte available |
| in_data | input | 8 | Upstream byte |
| in_err | input | 1 | Upstream byte is uncorrectable |
| in_ready | output | 1 | FIFO can take a byte |
| out_clk | output | 1 | Output data clock, rising edge active |
| out_stb | output | 1 | Output strobe |
| out_sync | output | 1 | Packet start marker |
| out_valid | output | 1 | Output data qualifier |
| out_data | output | 8 | Output byte, or bit 0 in serial form |

## Verification
The bench goes after packet-boundary counting at both lengths. A counter that is off by one would mark the wrong byte with `out_sync`, and every packet after it would drift. Serial checks compare each bit against the expected byte, so a least-significant-bit-first order or a skipped bit shows up at once. In the per-byte marking mode, a strobe or sync that stays high for all eight bits is caught on bit 1. Paced runs measure every rise-to-rise and fall-to-rise interval, so a period off by one, or a pace of 1 not held at 2, breaks the timing checks. Those runs also keep the FIFO full, so a byte dropped or repeated under back-pressure surfaces as a scoreboard mismatch.

// File: rtl/tsfmt_pkg.sv
// Shared constants, the FIFO word type and the packet length selector for
// the transport packet output formatter.
package tsfmt_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int LEN_LONG  = 188;
    localparam int LEN_SHORT = 144;
    localparam int CNT_W     = $clog2(LEN_LONG);

    // One FIFO entry: the byte and its uncorrectable flag.
    typedef struct packed {
        logic              err;
        logic [BYTE_W-1:0] data;
    } fmt_word_t;

    // Packet length in bytes for the selected broadcast format.
    function automatic logic [CNT_W-1:0] pkt_len(input logic short_sel);
        return short_sel ? CNT_W'(LEN_SHORT) : CNT_W'(LEN_LONG);
    endfunction

endpackage

// File: rtl/tsfmt_fifo.sv
// Input FIFO for the formatter.
// It buffers upstream bytes together with their error flags.
// Assumes the caller never pushes while full and never pops while empty.
// The read data is the head entry and is valid whenever empty is low.
module tsfmt_fifo
    import tsfmt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  fmt_word_t wdata,
    output logic      full,
    input  logic      pop,
    output fmt_word_t rdata,
    output logic      empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    fmt_word_t         mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R10: occupancy never exceeds the depth.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R10: the sequencer only pops when an entry is present.
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/tsfmt_pacer.sv
// Unit timer for the formatter.
// It counts clocks within one output unit and derives the output data clock:
// low for the first floor(P/2) clocks of the unit, then high.
// unit_end marks the last clock of each unit.
// Assumes regulated and pace stay constant while out of reset.
module tsfmt_pacer #(
    parameter int PACE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              regulated,
    input  logic [PACE_W-1:0] pace,
    output logic              unit_end,
    output logic              data_clk
);

    logic [PACE_W-1:0] period;
    logic [PACE_W-1:0] half;
    logic [PACE_W-1:0] phase;

    // Unit length: 2 clocks in burst timing, otherwise the pace held at a minimum of 2.
    always_comb begin
        period = PACE_W'(2);
        if (regulated && (pace > PACE_W'(2))) begin
            period = pace;
        end
        half = period >> 1;
    end

    assign unit_end = (phase >= period - PACE_W'(1));
    assign data_clk = (phase >= half);

    // Phase counter that wraps at the end of each unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (unit_end) begin
            phase <= '0;
        end else begin
            phase <= phase + PACE_W'(1);
        end
    end

    // R8: the phase stays inside the programmed unit length.
    p_phase_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase < period);

endmodule

// File: rtl/tsfmt_seq.sv
// Byte and bit sequencer for the formatter.
// At every unit boundary it either steps to the next bit of the current byte
// (serial form) or takes the next byte from the FIFO.
// If the FIFO is empty it shows an idle unit instead.
// It counts bytes modulo the packet length to flag the first byte of each packet.
module tsfmt_seq
    import tsfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_end,
    input  logic             serial,
    input  logic             short_sel,
    input  logic             fifo_empty,
    input  fmt_word_t        fifo_rdata,
    output logic             fifo_pop,
    output logic             live,
    output fmt_word_t        cur_word,
    output logic             first,
    output logic [BIT_W-1:0] bit_idx
);

    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] len;
    logic             more_bits;

    assign len       = pkt_len(short_sel);
    assign more_bits = serial && live && (bit_idx != BIT_W'(BYTE_W - 1));
    assign fifo_pop  = unit_end && !more_bits && !fifo_empty;

    // Load the next bit, the next byte or an idle unit at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live     <= 1'b0;
            cur_word <= '0;
            first    <= 1'b0;
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (unit_end) begin
            if (more_bits) begin
                bit_idx <= bit_idx + BIT_W'(1);
            end else if (!fifo_empty) begin
                live     <= 1'b1;
                cur_word <= fifo_rdata;
                first    <= (byte_cnt == '0);
                bit_idx  <= '0;
                byte_cnt <= (byte_cnt == len - CNT_W'(1)) ? '0 : byte_cnt + CNT_W'(1);
            end else begin
                live    <= 1'b0;
                first   <= 1'b0;
                bit_idx <= '0;
            end
        end
    end

    // R1: the position within the packet stays below the packet length.
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt < len);

    // R3: the bit index moves only at a unit boundary.
    p_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_idx) |-> $past(unit_end));

endmodule

// File: rtl/ts_pkt_formatter.sv
// Transport packet output formatter, top level.
// It buffers decoded bytes in a FIFO and emits them as bytes or as bits, in
// burst or paced timing, with a data clock, strobe, packet-start marker and
// valid qualifier.
// Assumes all cfg_* inputs stay constant while out of reset.
module ts_pkt_formatter
    import tsfmt_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int PACE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_short_len,
    input  logic              cfg_serial,
    input  logic              cfg_regulated,
    input  logic              cfg_byte_mark,
    input  logic [PACE_W-1:0] cfg_pace,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_err,
    output logic              in_ready,
    output logic              out_clk,
    output logic              out_stb,
    output logic              out_sync,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    logic             fifo_full;
    logic             fifo_empty;
    logic             fifo_push;
    logic             fifo_pop;
    fmt_word_t        fifo_wdata;
    fmt_word_t        fifo_rdata;
    logic             unit_end;
    logic             live;
    fmt_word_t        cur_word;
    logic             first;
    logic [BIT_W-1:0] bit_idx;
    logic             byte_mark_mode;
    logic             bit_now;

    assign in_ready         = !fifo_full;
    assign fifo_push        = in_valid && !fifo_full;
    assign fifo_wdata.err   = in_err;
    assign fifo_wdata.data  = in_data;

    tsfmt_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .full  (fifo_full),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty)
    );

    tsfmt_pacer #(
        .PACE_W (PACE_W)
    ) pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .regulated (cfg_regulated),
        .pace      (cfg_pace),
        .unit_end  (unit_end),
        .data_clk  (out_clk)
    );

    tsfmt_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit_end   (unit_end),
        .serial     (cfg_serial),
        .short_sel  (cfg_short_len),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .fifo_pop   (fifo_pop),
        .live       (live),
        .cur_word   (cur_word),
        .first      (first),
        .bit_idx    (bit_idx)
    );

    assign byte_mark_mode = cfg_serial && cfg_regulated && cfg_byte_mark;
    assign bit_now        = cur_word.data[BIT_W'(BYTE_W - 1) - bit_idx];

    // Output mux: data, qualifier, packet marker and strobe for the current unit.
    always_comb begin
        out_data = '0;
        if (live) begin
            out_data = cfg_serial ? {{(BYTE_W-1){1'b0}}, bit_now} : cur_word.data;
        end
        out_valid = live && !cur_word.err;
        out_sync  = live && first && (!byte_mark_mode || (bit_idx == '0));
        out_stb   = live && (byte_mark_mode ? (bit_idx == '0) : out_clk);
    end

    // R9: output data changes only together with a falling data clock.
    p_data_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> $fell(out_clk));

    // R4: a packet marker starts only at a unit boundary.
    p_sync_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_sync) |-> $fell(out_clk));

    // R2: outside the byte marking mode the strobe sits in the high phase.
    p_stb_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !byte_mark_mode) |-> out_clk);

    // R10: back-pressure is shown whenever no byte can be taken.
    p_ready_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (fifo_pop || !in_ready || $past(fifo_pop)));

endmodule

// File: tb/ts_pkt_formatter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for the transport packet output formatter.
// The driver task pushes an expected entry {first, err, data} for every
// byte the block accepts. The monitor pops one entry for each byte it sees
// and compares data, marker, strobe and qualifier at each data clock rise.
module ts_pkt_formatter_tb_top;

    localparam int PACE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_short_len = 1'b0;
    logic              cfg_serial = 1'b0;
    logic              cfg_regulated = 1'b0;
    logic              cfg_byte_mark = 1'b0;
    logic [PACE_W-1:0] cfg_pace = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_err = 1'b0;
    logic              in_ready;
    logic              out_clk;
    logic              out_stb;
    logic              out_sync;
    logic              out_valid;
    logic [7:0]        out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [9:0] exp_q[$];
    int         tx_idx;
    int         m_len;
    int         exp_period;
    int         phase_id;
    bit         m_serial, m_reg, m_mark, mon_en, saw_full;
    bit         prev_clk, have_rise, have_fall, collecting;
    int         last_rise, last_fall, bitn;
    logic [9:0] cur_e;

    ts_pkt_formatter #(.FIFO_DEPTH(4), .PACE_W(PACE_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_short_len (cfg_short_len),
        .cfg_serial    (cfg_serial),
        .cfg_regulated (cfg_regulated),
        .cfg_byte_mark (cfg_byte_mark),
        .cfg_pace      (cfg_pace),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_err        (in_err),
        .in_ready      (in_ready),
        .out_clk       (out_clk),
        .out_stb       (out_stb),
        .out_sync      (out_sync),
        .out_valid     (out_valid),
        .out_data      (out_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Count a check and report a mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Enter reset, apply a configuration, check the reset state and release.
    task automatic start_phase(input bit short_len, input bit serial, input bit reg_t,
                               input bit mark, input int pace);
        @(negedge clk);
        rst_n  = 1'b0;
        mon_en = 1'b0;
        cfg_short_len = short_len;
        cfg_serial    = serial;
        cfg_regulated = reg_t;
        cfg_byte_mark = mark;
        cfg_pace      = PACE_W'(pace);
        m_len    = short_len ? 144 : 188;
        m_serial = serial;
        m_reg    = reg_t;
        m_mark   = serial && reg_t && mark;
        exp_period = reg_t ? ((pace < 2) ? 2 : pace) : 2;
        repeat (3) @(negedge clk);
        // R11: reset state of every output.
        chk(out_clk == 1'b0,   "R11", out_clk, 0);
        chk(out_stb == 1'b0,   "R11", out_stb, 0);
        chk(out_sync == 1'b0,  "R11", out_sync, 0);
        chk(out_valid == 1'b0, "R11", out_valid, 0);
        chk(out_data == 8'h00, "R11", out_data, 0);
        chk(in_ready == 1'b1,  "R11", in_ready, 1);
        exp_q.delete();
        tx_idx = 0;
        prev_clk = 1'b0; have_rise = 1'b0; have_fall = 1'b0;
        collecting = 1'b0; saw_full = 1'b0; bitn = 0;
        phase_id++;
        rst_n  = 1'b1;
        mon_en = 1'b1;
    endtask

    // Driver: offers count bytes and records the expected entry on acceptance.
    task automatic send_bytes(input int count, input bit gaps);
        for (int i = 0; i < count; i++) begin
            logic [7:0] d;
            logic       e;
            logic       f;
            @(negedge clk);
            d = 8'((tx_idx * 37) + 91 + (phase_id * 13));
            e = ((tx_idx % 29) == 11);
            f = ((tx_idx % m_len) == 0);
            in_data  = d;
            in_err   = e;
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            exp_q.push_back({f, e, d});
            tx_idx++;
            if (gaps && ((i % 10) == 9)) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (3) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Let the output drain and confirm nothing is left over.
    task automatic finish_phase(input bit expect_full);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (exp_period * 20) @(negedge clk);
        chk(!collecting, "R10", collecting, 0);
        if (expect_full) chk(saw_full, "R10", saw_full, 1);
    endtask

    // Monitor: timing checks on every data clock edge, scoreboard on rises.
    always @(negedge clk) begin
        if (mon_en) begin
            if (!in_ready) saw_full = 1'b1;
            if (!out_clk && !m_mark) chk(out_stb == 1'b0, "R2", out_stb, 0);
            if (!out_clk && prev_clk) begin
                last_fall = cyc;
                have_fall = 1'b1;
            end
            if (out_clk && !prev_clk) begin
                if (have_rise) chk((cyc - last_rise) == exp_period, m_reg ? "R8" : "R7",
                                   cyc - last_rise, exp_period);
                if (have_fall) chk((cyc - last_fall) == exp_period / 2, "R9",
                                   cyc - last_fall, exp_period / 2);
                last_rise = cyc;
                have_rise = 1'b1;
                if (m_serial) begin
                    if (!collecting && out_stb) begin
                        chk(exp_q.size() > 0, "R10", exp_q.size(), 1);
                        cur_e = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h0;
                        collecting = 1'b1;
                        bitn = 0;
                    end
                    if (collecting) begin
                        chk(out_data[0] == cur_e[7 - bitn], "R3", out_data[0], cur_e[7 - bitn]);
                        chk(out_data[7:1] == 7'h0, "R3", out_data[7:1], 0);
                        chk(out_valid == !cur_e[8], "R6", out_valid, !cur_e[8]);
                        if (m_mark) begin
                            chk(out_sync == (cur_e[9] && bitn == 0), "R5", out_sync,
                                cur_e[9] && bitn == 0);
                            chk(out_stb == (bitn == 0), "R5", out_stb, bitn == 0);
                        end else begin
                            chk(out_sync == cur_e[9], cur_e[9] ? "R1" : "R4", out_sync, cur_e[9]);
                            chk(out_stb == 1'b1, "R3", out_stb, 1);
                        end
                        bitn++;
                        if (bitn == 8) collecting = 1'b0;
                    end else begin
                        chk(out_valid == 1'b0, "R6", out_valid, 0);
                        chk(out_sync == 1'b0,  "R6", out_sync, 0);
                    end
                end else begin
                    if (out_stb) begin
                        chk(exp_q.size() > 0, "R10", exp_q.size(), 1);
                        cur_e = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h0;
                        chk(out_data == cur_e[7:0], "R2", out_data, cur_e[7:0]);
                        chk(out_sync == cur_e[9], cur_e[9] ? "R1" : "R4", out_sync, cur_e[9]);
                        chk(out_valid == !cur_e[8], "R6", out_valid, !cur_e[8]);
                    end else begin
                        chk(out_valid == 1'b0, "R6", out_valid, 0);
                        chk(out_sync == 1'b0,  "R6", out_sync, 0);
                    end
                end
            end
            prev_clk = out_clk;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hang expected=done");
        summary();
    end

    initial begin
        phase_id = 0;
        mon_en   = 1'b0;
        // Parallel, burst timing, 188-byte packets, upstream gaps.
        start_phase(1'b0, 1'b0, 1'b0, 1'b0, 0);
        send_bytes(2 * 188 + 10, 1'b1);
        finish_phase(1'b0);
        // Serial, burst timing, 144-byte packets, FIFO back-pressure.
        start_phase(1'b1, 1'b1, 1'b0, 1'b0, 0);
        send_bytes(144 + 5, 1'b0);
        finish_phase(1'b1);
        // Parallel, paced every 3 clocks, 144-byte packets.
        start_phase(1'b1, 1'b0, 1'b1, 1'b0, 3);
        send_bytes(150, 1'b0);
        finish_phase(1'b1);
        // Serial paced every 4 clocks, strobe per bit, 188-byte packets.
        start_phase(1'b0, 1'b1, 1'b1, 1'b0, 4);
        send_bytes(190, 1'b0);
        finish_phase(1'b1);
        // Serial paced with pace 1 (held at 2), strobe per byte, 144-byte packets.
        start_phase(1'b1, 1'b1, 1'b1, 1'b1, 1);
        send_bytes(146, 1'b1);
        finish_phase(1'b0);
        summary();
    end

endmodule